// File: doc/BRIEF.md
# Compressed Predicated Compare Decoder

This block takes a 16-bit compressed instruction from quadrant 1 whose branch encoding has been given a new meaning: instead of jumping, it compares two registers and records the result in a predicate register. The bits that would normally hold the branch offset now carry three things. They name a predicate target and a second source, and one bit selects integer or floating-point operands. The block turns the instruction into a normalized compare request. That request holds full register numbers for both sources and the predicate, an integer/float flag and a two-bit compare operation. A downstream compare unit then executes it.

The block has only four compare operators. Greater-than and greater-or-equal are produced by exchanging the sources, and a separate swap input requests that exchange. The result is registered and offered under a valid/ready handshake. Any instruction that is not one of the reinterpreted compares is flagged as unsupported for a single cycle.

Top module: `cpc_decoder`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: Compact register fields map to full numbers 8 to 15: `out_src1` = 8 + instr[9:7], `out_src2` = 8 + instr[4:2], `out_pred` = 8 + instr[12:10].
- R3: `out_is_float` equals instr[6] (1 means both sources are floating-point registers).
- R4: `out_op` = {instr[13], instr[5]}, with 0 equal, 1 not-equal, 2 less-than, 3 less-or-equal.
- R5: When `in_swap` is 1 and the operation is less-than or less-or-equal, `out_src1` and `out_src2` are exchanged.
- R6: When `in_swap` is 1 with equal or not-equal, the sources are not exchanged.
- R7: An instruction with instr[1:0] other than 01, or with instr[15:13] other than 110 or 111, yields `out_unsup` = 1 with `out_valid` high for exactly one cycle, independent of `out_ready`.
- R8: An instruction is taken on a clock edge where `in_valid` and `in_ready` are both 1, and `out_valid` is 1 in the following cycle. A supported result stays valid and stable while `out_ready` is 0. `in_ready` is 0 during that time, and input offered then is ignored.
- R9: A clock edge with `out_valid` and `out_ready` both 1 clears `out_valid` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Block can take an instruction |
| in_instr | input | 16 | Compressed instruction word |
| in_swap | input | 1 | Request exchanged-operand form |
| out_valid | output | 1 | Compare request available |
| out_ready | input | 1 | Consumer takes the request |
| out_src1 | output | 5 | First source register number |
| out_src2 | output | 5 | Second source register number |
| out_pred | output | 5 | Predicate destination register number |
| out_is_float | output | 1 | Sources are floating-point registers |
| out_op | output | 2 | Compare operation |
| out_unsup | output | 1 | Instruction is not a supported compare |

## Verification
On every cycle, the assertions check the handshake: a held result stays stable, an unsupported result lasts one cycle, an accepted result drains, and a taken instruction appears. They also check the swap rule on the combinational path: an exchange happens only for less-than forms and never for equality forms. The bench scenarios are needed for the field-to-register mapping, the operation encoding and the float select. They also show that the two unsupported conditions are detected, and that input offered while a result is held leaves no trace.

// File: rtl/cpc_pkg.sv
// Shared types for the compressed predicated compare decoder.
// Assumes a 32-entry register file, so full register numbers are 5 bits.
package cpc_pkg;
    localparam int REG_AW = 5;

    typedef enum logic [1:0] {
        CMP_EQ = 2'd0,
        CMP_NE = 2'd1,
        CMP_LT = 2'd2,
        CMP_LE = 2'd3
    } cmp_op_e;

    typedef struct packed {
        logic [REG_AW-1:0] src1;
        logic [REG_AW-1:0] src2;
        logic [REG_AW-1:0] pred;
        logic              is_float;
        cmp_op_e           op;
        logic              unsup;
    } cmp_req_t;
endpackage

// File: rtl/cpc_fields.sv
// Splits a 16-bit instruction into a compare request and flags anything
// that is not a quadrant-1 reinterpreted compare (funct3 110/111).
// Assumes compact register fields name registers REG_BASE..REG_BASE+7.
module cpc_fields
    import cpc_pkg::*;
#(
    parameter int INSN_W   = 16,
    parameter int CREG_W   = 3,
    parameter int REG_BASE = 8
) (
    input  logic [INSN_W-1:0] instr,
    output cmp_req_t          req
);
    localparam logic [1:0] QUAD_CODE = 2'b01;
    localparam logic [1:0] F3_HIGH   = 2'b11;

    logic [CREG_W-1:0] f_pred, f_s1, f_s2;
    logic              legal;

    // Pull out fields and judge whether the encoding is supported.
    always_comb begin
        f_pred = instr[12:10];
        f_s1   = instr[9:7];
        f_s2   = instr[4:2];
        legal  = (instr[1:0] == QUAD_CODE) && (instr[15:14] == F3_HIGH);
    end

    // Build the normalized request; unsupported input yields only the flag.
    always_comb begin
        req = '0;
        if (legal) begin
            req.src1     = REG_AW'(REG_BASE) + REG_AW'(f_s1);
            req.src2     = REG_AW'(REG_BASE) + REG_AW'(f_s2);
            req.pred     = REG_AW'(REG_BASE) + REG_AW'(f_pred);
            req.is_float = instr[6];
            req.op       = cmp_op_e'({instr[13], instr[5]});
        end else begin
            req.unsup    = 1'b1;
        end
    end
endmodule

// File: rtl/cpc_swap.sv
// Exchanges the two sources when asked, but only for the ordered compares,
// so greater-than forms are built from less-than forms.
module cpc_swap
    import cpc_pkg::*;
(
    input  logic     swap,
    input  cmp_req_t req_in,
    output cmp_req_t req_out
);
    logic ordered;

    // Apply the exchange only to less-than and less-or-equal.
    always_comb begin
        ordered = (req_in.op == CMP_LT) || (req_in.op == CMP_LE);
        req_out = req_in;
        if (swap && ordered && !req_in.unsup) begin
            req_out.src1 = req_in.src2;
            req_out.src2 = req_in.src1;
        end
    end

    // Guard the exchange rule on the combinational path.
    always_comb begin
        if (!req_in.unsup && (req_in.op == CMP_EQ || req_in.op == CMP_NE))
            AST_EQ_NO_SWAP: assert (req_out.src1 == req_in.src1 && req_out.src2 == req_in.src2); // R6
        if (!req_in.unsup && swap && (req_in.op == CMP_LT || req_in.op == CMP_LE))
            AST_ORDERED_SWAP: assert (req_out.src1 == req_in.src2 && req_out.src2 == req_in.src1); // R5
    end
endmodule

// File: rtl/cpc_hold.sv
// One-entry output register with valid/ready. A supported request waits
// for the consumer; an unsupported one is shown for one cycle only.
// Assumes no input is taken while a request is held.
module cpc_hold
    import cpc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     in_valid,
    output logic     in_ready,
    input  cmp_req_t d,
    output logic     out_valid,
    input  logic     out_ready,
    output cmp_req_t q
);
    logic     full;
    cmp_req_t data;
    logic     take;

    // Ready only when empty.
    always_comb begin
        in_ready = !full;
        take     = in_valid && !full;
    end

    // Capture, hold and release the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
        end else if (take) begin
            full <= 1'b1;
            data <= d;
        end else if (full && (out_ready || data.unsup)) begin
            full <= 1'b0;
        end
    end

    // Drive outputs from the register.
    always_comb begin
        out_valid = full;
        q         = data;
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !q.unsup) |=> (out_valid && $stable(q))); // R8
    AST_UNSUP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && q.unsup) |=> !out_valid); // R7
    AST_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> !out_valid); // R9
    AST_TAKE_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid); // R8
endmodule

// File: rtl/cpc_decoder.sv
// Top: decodes a reinterpreted compressed branch into a registered
// predicated compare request with a valid/ready handshake.
module cpc_decoder
    import cpc_pkg::*;
#(
    parameter int INSN_W   = 16,
    parameter int CREG_W   = 3,
    parameter int REG_BASE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [INSN_W-1:0] in_instr,
    input  logic              in_swap,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [REG_AW-1:0] out_src1,
    output logic [REG_AW-1:0] out_src2,
    output logic [REG_AW-1:0] out_pred,
    output logic              out_is_float,
    output logic [1:0]        out_op,
    output logic              out_unsup
);
    cmp_req_t raw_req, sw_req, held;

    cpc_fields #(.INSN_W(INSN_W), .CREG_W(CREG_W), .REG_BASE(REG_BASE)) u_fields (
        .instr (in_instr),
        .req   (raw_req)
    );

    cpc_swap u_swap (
        .swap    (in_swap),
        .req_in  (raw_req),
        .req_out (sw_req)
    );

    cpc_hold u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .d         (sw_req),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .q         (held)
    );

    // Flatten the held request onto the ports.
    always_comb begin
        out_src1     = held.src1;
        out_src2     = held.src2;
        out_pred     = held.pred;
        out_is_float = held.is_float;
        out_op       = held.op;
        out_unsup    = held.unsup;
    end
endmodule

// File: tb/sim_cpc_decoder.sv
`timescale 1ns/1ps
module sim_cpc_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_instr = 16'h0;
    logic        in_swap = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [4:0]  out_src1, out_src2, out_pred;
    logic        out_is_float;
    logic [1:0]  out_op;
    logic        out_unsup;
    int          n_run = 0;
    int          n_fail = 0;

    always #2 clk = ~clk;

    cpc_decoder u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_instr(in_instr), .in_swap(in_swap), .out_valid(out_valid),
        .out_ready(out_ready), .out_src1(out_src1), .out_src2(out_src2),
        .out_pred(out_pred), .out_is_float(out_is_float), .out_op(out_op),
        .out_unsup(out_unsup)
    );

    function automatic logic [15:0] mk(input logic [2:0] f3, input logic [2:0] p,
                                       input logic [2:0] s1, input logic fl,
                                       input logic ex, input logic [2:0] s2,
                                       input logic [1:0] qd);
        return {f3, p, s1, fl, ex, s2, qd};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Offer one instruction at a falling edge; it is taken at the next rise.
    task automatic send(input logic [15:0] ins, input logic sw);
        @(negedge clk);
        in_instr = ins; in_swap = sw; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; in_swap = 1'b0;
    endtask

    task automatic drain();
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        chk("R9 drained", out_valid, 0);
    endtask

    task automatic t_reset();
        chk("R1 out_valid", out_valid, 0);
        chk("R1 in_ready", in_ready, 1);
    endtask

    task automatic t_basic(input logic [2:0] f3, input logic [2:0] p, input logic [2:0] s1,
                           input logic fl, input logic ex, input logic [2:0] s2,
                           input logic sw);
        logic [1:0] eop = {f3[0], ex};
        logic       ord = eop[1];
        logic [4:0] e1 = 5'd8 + 5'(s1);
        logic [4:0] e2 = 5'd8 + 5'(s2);
        send(mk(f3, p, s1, fl, ex, s2, 2'b01), sw);
        chk("R8 valid", out_valid, 1);
        chk("R7 not unsup", out_unsup, 0);
        chk("R2 pred", out_pred, 5'd8 + 5'(p));
        chk("R3 float", out_is_float, fl);
        chk("R4 op", out_op, eop);
        if (sw && ord) begin
            chk("R5 src1", out_src1, e2);
            chk("R5 src2", out_src2, e1);
        end else if (sw) begin
            chk("R6 src1", out_src1, e1);
            chk("R6 src2", out_src2, e2);
        end else begin
            chk("R2 src1", out_src1, e1);
            chk("R2 src2", out_src2, e2);
        end
        drain();
    endtask

    task automatic t_unsup(input logic [15:0] ins);
        send(ins, 1'b0);
        chk("R7 valid", out_valid, 1);
        chk("R7 unsup", out_unsup, 1);
        @(negedge clk);
        chk("R7 one cycle", out_valid, 0);
    endtask

    task automatic t_hold();
        send(mk(3'b110, 3'd2, 3'd5, 1'b0, 1'b1, 3'd6, 2'b01), 1'b0);
        in_instr = mk(3'b111, 3'd7, 3'd0, 1'b1, 1'b0, 3'd1, 2'b01);
        in_valid = 1'b1;
        repeat (3) @(negedge clk);
        chk("R8 in_ready low", in_ready, 0);
        chk("R8 still valid", out_valid, 1);
        chk("R8 src1 held", out_src1, 5'd13);
        chk("R8 pred held", out_pred, 5'd10);
        chk("R8 op held", out_op, 2'd1);
        chk("R8 float held", out_is_float, 0);
        in_valid = 1'b0;
        drain();
        @(negedge clk);
        chk("R8 ignored input not taken", out_valid, 0);
    endtask

    initial begin
        #800000;
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic(3'b110, 3'd3, 3'd1, 1'b0, 1'b0, 3'd4, 1'b0); // EQ int
        t_basic(3'b110, 3'd7, 3'd0, 1'b1, 1'b1, 3'd7, 1'b0); // NE float
        t_basic(3'b111, 3'd0, 3'd2, 1'b0, 1'b0, 3'd5, 1'b1); // LT swapped R5
        t_basic(3'b111, 3'd5, 3'd6, 1'b1, 1'b1, 3'd3, 1'b1); // LE swapped R5
        t_basic(3'b111, 3'd1, 3'd4, 1'b0, 1'b1, 3'd2, 1'b0); // LE plain
        t_basic(3'b110, 3'd6, 3'd1, 1'b0, 1'b0, 3'd2, 1'b1); // EQ swap ignored R6
        t_basic(3'b110, 3'd4, 3'd3, 1'b1, 1'b1, 3'd0, 1'b1); // NE swap ignored R6
        t_unsup(mk(3'b110, 3'd1, 3'd1, 1'b0, 1'b0, 3'd1, 2'b10)); // bad quadrant R7
        t_unsup(mk(3'b101, 3'd1, 3'd1, 1'b0, 1'b0, 3'd1, 2'b01)); // bad funct3 R7
        t_unsup(mk(3'b111, 3'd2, 3'd2, 1'b1, 1'b1, 3'd2, 2'b00)); // bad quadrant R7
        t_hold();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule